// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of a multi-input successive-approximation converter. It issues a one-cycle start pulse with a channel number to the converter. It then waits for a done strobe that returns a 12-bit value and an error flag, and records the outcome. Software-facing settings arrive as plain input ports that a register decoder outside the block drives. The block has no bus logic of its own.

Conversions can be launched one at a time, or run continuously for as long as a level input is held. In continuous mode a divider with an integer part and an 8-bit fractional part spaces the starts. A nonzero round-robin mask makes the channel select hop, after every conversion, to the next enabled input. Each finished result can be formatted and pushed into a four-entry FIFO. Formatting can narrow the result to one byte and can tag the entry with its error flag. The FIFO fill level is compared with a threshold to raise a DMA request and a raw interrupt. The raw interrupt is then masked and can be forced.

Top module: `adc_seq_top`

## Requirements
- R1: `ready` is 1 exactly when `adc_en` is 1 and no conversion is outstanding. With `adc_en` at 0, no start pulse is issued.
- R2: A cycle with `start_once` high while `ready` is 1 issues exactly one `conv_start` pulse. `start_once` seen while a conversion is outstanding is ignored.
- R3: While `start_many` is high, consecutive starts are spaced by max(`div_int` + c + 1, converter busy time + 1) cycles. Here c is the carry out of an 8-bit accumulator that adds `div_frac` at every start and is cleared by reset. A zero divisor gives back-to-back conversions.
- R4: When `rr_mask` is nonzero, each completed conversion moves `ch_sel` to the first channel among (cur+1, cur+2, ... cur+5) mod 5 whose mask bit is set. When the mask is zero, `ch_sel` stays put. `ch_wr_en` loads `ch_sel` from `ch_wr_val`, and `conv_ch` carries `ch_sel` at each start.
- R5: `last_result` and `last_err` take the value and error flag of the most recent conversion. `err_sticky` sets on any errored conversion and clears only on a `clr_err` pulse.
- R6: With `fifo_en` set, each completed conversion pushes one entry. Bits [11:0] hold the value, bits [14:12] are zero, and bit 15 is the conversion error flag if `err_tag_en` is set and 0 otherwise.
- R7: With `shift_en` set, the pushed value is the result shifted right by 4. It occupies bits [7:0], and bits [11:8] are zero.
- R8: The FIFO holds 4 entries in first-in first-out order. `fifo_rdata` shows the oldest entry, and `fifo_pop` removes it. `fifo_level` counts the entries, with `fifo_full` at 4 and `fifo_empty` at 0.
- R9: A push while full is dropped and sets `fifo_over`. The flag holds until a `clr_over` pulse.
- R10: A pop while empty reads 0, leaves the level at 0 and sets `fifo_under`. The flag holds until a `clr_under` pulse.
- R11: `irq_raw` is 1 when `fifo_level` >= `fifo_thresh`. `dreq` equals `irq_raw` when `dreq_en` is set and is 0 otherwise.
- R12: `irq` = (`irq_raw` AND `irq_en`) OR `irq_force`.
- R13: After reset the FIFO is empty, the channel is 0, the result is 0 and all sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_en | input | 1 | Converter enable |
| start_once | input | 1 | Launch one conversion |
| start_many | input | 1 | Keep conversions running while high |
| ch_wr_en | input | 1 | Load channel select |
| ch_wr_val | input | 3 | Channel to load |
| rr_mask | input | 5 | Round-robin channel mask |
| div_int | input | 16 | Pacing divisor, integer part |
| div_frac | input | 8 | Pacing divisor, fraction in 1/256 |
| fifo_en | input | 1 | Push results into the FIFO |
| err_tag_en | input | 1 | Put the error flag in entry bit 15 |
| shift_en | input | 1 | Narrow pushed values to 8 bits |
| dreq_en | input | 1 | Enable the DMA request |
| fifo_thresh | input | 4 | Level threshold |
| irq_en | input | 1 | Interrupt enable |
| irq_force | input | 1 | Interrupt force |
| clr_err | input | 1 | Clear sticky error |
| clr_over | input | 1 | Clear overflow flag |
| clr_under | input | 1 | Clear underflow flag |
| fifo_pop | input | 1 | Remove the oldest entry |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 3 | Channel for the conversion |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result |
| conv_err | input | 1 | Converter error flag |
| ready | output | 1 | A new conversion can start |
| ch_sel | output | 3 | Current channel select |
| last_result | output | 12 | Most recent result |
| last_err | output | 1 | Most recent error flag |
| err_sticky | output | 1 | Some conversion has errored |
| fifo_rdata | output | 16 | Oldest FIFO entry, 0 when empty |
| fifo_level | output | 4 | FIFO fill level |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_over | output | 1 | Sticky overflow |
| fifo_under | output | 1 | Sticky underflow |
| dreq | output | 1 | DMA request |
| irq_raw | output | 1 | Raw FIFO interrupt |
| irq | output | 1 | Masked and forced interrupt |

## Verification
The assertions watch the cycle-level rules on every cycle. A start is always followed by a busy converter, and ready comes back after a done. The sticky flags hold, the FIFO level never passes its depth, and a full push leaves the level alone. A rotated channel always lands on a masked input, the pacing counter restarts correctly at each start, and a forced interrupt is always visible. The exact values only appear in the bench scenarios. These are the start spacing produced by the fractional accumulator, the order of channels under every mask, and the formatting of entries under each tag and shift setting. They also cover the FIFO contents after overflow and the threshold outputs at every level.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADC_CH_W    = 3;
  localparam int ADC_NCH     = 5;
  localparam int ADC_DATA_W  = 12;
  localparam int ADC_ENTRY_W = 16;
  localparam int ADC_FRAC_W  = 8;
  localparam int ADC_SHIFT   = 4;

  // Next channel after cur whose mask bit is set, searching cur+1 .. cur+nch.
  function automatic logic [ADC_CH_W-1:0] rr_next(input logic [ADC_CH_W-1:0] cur,
                                                  input logic [7:0] mask,
                                                  input int nch);
    logic found;
    int   idx;
    rr_next = cur;
    found   = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      if (!found && i <= nch) begin
        idx = (int'(cur) + i) % nch;
        if (mask[idx[2:0]]) begin
          rr_next = ADC_CH_W'(idx);
          found   = 1'b1;
        end
      end
    end
  endfunction

  // FIFO entry: {tagged error, 3'b0, value}, value optionally narrowed to a byte.
  function automatic logic [ADC_ENTRY_W-1:0] fmt_entry(input logic [ADC_DATA_W-1:0] data,
                                                       input logic err,
                                                       input logic tag,
                                                       input logic shift);
    logic [ADC_DATA_W-1:0] v;
    v = shift ? (data >> ADC_SHIFT) : data;
    return {tag & err, 3'b000, v};
  endfunction

  // Fractional accumulator step: {carry, new accumulator}.
  function automatic logic [ADC_FRAC_W:0] pace_step(input logic [ADC_FRAC_W-1:0] acc,
                                                    input logic [ADC_FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction
endpackage

// File: rtl/adc_pacer.sv
module adc_pacer
  import adc_seq_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INT_W-1:0]      div_int,
  input  logic [ADC_FRAC_W-1:0] div_frac,
  input  logic                  start_evt,
  output logic                  pace_ok
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      target_q;
  logic [ADC_FRAC_W-1:0] acc_q;
  logic [ADC_FRAC_W:0]   step;

  assign step = pace_step(acc_q, div_frac);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      target_q <= '0;
      acc_q    <= '0;
    end else if (start_evt) begin
      cnt_q    <= '0;
      acc_q    <= step[ADC_FRAC_W-1:0];
      target_q <= CNT_W'(div_int) + CNT_W'(step[ADC_FRAC_W]);
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign pace_ok = cnt_q >= target_q;

  AST_PACE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (pace_ok == (target_q == '0))); // R3
endmodule

// File: rtl/adc_chan_rr.sv
module adc_chan_rr
  import adc_seq_pkg::*;
#(
  parameter int NCH  = ADC_NCH,
  parameter int CH_W = ADC_CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_val,
  input  logic [NCH-1:0]  mask,
  input  logic            adv,
  output logic [CH_W-1:0] ch
);
  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] next_ch;
  logic [7:0]      mask8;

  assign mask8   = 8'(mask);
  assign next_ch = rr_next(ch_q, mask8, NCH);

  always_ff @(posedge clk) begin
    if (!rst_n)              ch_q <= '0;
    else if (wr_en)          ch_q <= wr_val;
    else if (adv && |mask)   ch_q <= next_ch;
  end

  assign ch = ch_q;

  AST_RR_ON_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && |mask && !wr_en) |=> ((($past(mask8)) >> ch_q) & 8'h01) != 8'h00); // R4
  AST_RR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(adv && |mask)) |=> $stable(ch_q)); // R4
endmodule

// File: rtl/adc_fifo.sv
module adc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  input  logic                         clr_over,
  input  logic                         clr_under,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty,
  output logic                         over,
  output logic                         under
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] cnt_q;
  logic             over_q, under_q;
  logic             do_push, do_pop;

  assign full    = cnt_q == LVL_W'(DEPTH);
  assign empty   = cnt_q == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + LVL_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (push && full)        over_q <= 1'b1;
      else if (clr_over)       over_q <= 1'b0;
      if (pop && empty)        under_q <= 1'b1;
      else if (clr_under)      under_q <= 1'b0;
    end
  end

  assign rdata = empty ? '0 : mem_q[rd_q];
  assign level = cnt_q;
  assign over  = over_q;
  assign under = under_q;

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LVL_W'(DEPTH)); // R8
  AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (level == $past(level)) && over); // R9
  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !clr_over) |=> over); // R9
  AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !clr_under) |=> under); // R10
  AST_EMPTY_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R10
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NCH        = ADC_NCH,
  parameter int CH_W       = ADC_CH_W,
  parameter int DATA_W     = ADC_DATA_W,
  parameter int ENTRY_W    = ADC_ENTRY_W,
  parameter int INT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_OUT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adc_en,
  input  logic                  start_once,
  input  logic                  start_many,
  input  logic                  ch_wr_en,
  input  logic [CH_W-1:0]       ch_wr_val,
  input  logic [NCH-1:0]        rr_mask,
  input  logic [INT_W-1:0]      div_int,
  input  logic [ADC_FRAC_W-1:0] div_frac,
  input  logic                  fifo_en,
  input  logic                  err_tag_en,
  input  logic                  shift_en,
  input  logic                  dreq_en,
  input  logic [LVL_OUT_W-1:0]  fifo_thresh,
  input  logic                  irq_en,
  input  logic                  irq_force,
  input  logic                  clr_err,
  input  logic                  clr_over,
  input  logic                  clr_under,
  input  logic                  fifo_pop,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_ch,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic                  conv_err,
  output logic                  ready,
  output logic [CH_W-1:0]       ch_sel,
  output logic [DATA_W-1:0]     last_result,
  output logic                  last_err,
  output logic                  err_sticky,
  output logic [ENTRY_W-1:0]    fifo_rdata,
  output logic [LVL_OUT_W-1:0]  fifo_level,
  output logic                  fifo_full,
  output logic                  fifo_empty,
  output logic                  fifo_over,
  output logic                  fifo_under,
  output logic                  dreq,
  output logic                  irq_raw,
  output logic                  irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  // Named internal events
  logic               busy_q;
  logic               pace_ok;
  logic               start_req;
  logic               start_evt;
  logic               done_evt;
  logic               push_evt;
  logic [ENTRY_W-1:0] push_word;
  logic [LVL_W-1:0]   lvl;
  logic [DATA_W-1:0]  result_q;
  logic               last_err_q;
  logic               sticky_q;

  assign ready     = adc_en && !busy_q;
  assign start_req = start_once || (start_many && pace_ok);
  assign start_evt = ready && start_req;
  assign done_evt  = conv_done && busy_q;
  assign push_evt  = done_evt && fifo_en;
  assign push_word = fmt_entry(conv_data, conv_err, err_tag_en, shift_en);

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (start_evt) busy_q <= 1'b1;
    else if (done_evt)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q   <= '0;
      last_err_q <= 1'b0;
      sticky_q   <= 1'b0;
    end else begin
      if (done_evt) begin
        result_q   <= conv_data;
        last_err_q <= conv_err;
      end
      if (done_evt && conv_err) sticky_q <= 1'b1;
      else if (clr_err)         sticky_q <= 1'b0;
    end
  end

  adc_pacer #(.INT_W(INT_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_int  (div_int),
    .div_frac (div_frac),
    .start_evt(start_evt),
    .pace_ok  (pace_ok)
  );

  adc_chan_rr #(.NCH(NCH), .CH_W(CH_W)) u_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ch_wr_en),
    .wr_val(ch_wr_val),
    .mask  (rr_mask),
    .adv   (done_evt),
    .ch    (ch_sel)
  );

  adc_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .wdata    (push_word),
    .pop      (fifo_pop),
    .clr_over (clr_over),
    .clr_under(clr_under),
    .rdata    (fifo_rdata),
    .level    (lvl),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .over     (fifo_over),
    .under    (fifo_under)
  );

  assign conv_start  = start_evt;
  assign conv_ch     = ch_sel;
  assign last_result = result_q;
  assign last_err    = last_err_q;
  assign err_sticky  = sticky_q;
  assign fifo_level  = LVL_OUT_W'(lvl);
  assign irq_raw     = fifo_level >= fifo_thresh;
  assign dreq        = dreq_en && irq_raw;
  assign irq         = (irq_raw && irq_en) || irq_force;

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !ready && adc_en) |=> ready); // R1
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !ready); // R2
  AST_ERR_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr_err) |=> err_sticky); // R5
  AST_DREQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> irq_raw); // R11
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_force |-> irq); // R12
endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_en = 0, start_once = 0, start_many = 0, ch_wr_en = 0;
  logic [2:0] ch_wr_val = 0;
  logic [4:0] rr_mask = 0;
  logic [15:0] div_int = 0;
  logic [7:0] div_frac = 0;
  logic fifo_en = 0, err_tag_en = 0, shift_en = 0, dreq_en = 0;
  logic [3:0] fifo_thresh = 4'd1;
  logic irq_en = 0, irq_force = 0, clr_err = 0, clr_over = 0, clr_under = 0, fifo_pop = 0;
  logic conv_start;
  logic [2:0] conv_ch;
  logic conv_done, conv_err;
  logic [11:0] conv_data;
  logic ready, last_err, err_sticky, fifo_full, fifo_empty, fifo_over, fifo_under, dreq, irq_raw, irq;
  logic [2:0] ch_sel;
  logic [11:0] last_result;
  logic [15:0] fifo_rdata;
  logic [3:0] fifo_level;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .start_once(start_once), .start_many(start_many),
    .ch_wr_en(ch_wr_en), .ch_wr_val(ch_wr_val), .rr_mask(rr_mask), .div_int(div_int),
    .div_frac(div_frac), .fifo_en(fifo_en), .err_tag_en(err_tag_en), .shift_en(shift_en),
    .dreq_en(dreq_en), .fifo_thresh(fifo_thresh), .irq_en(irq_en), .irq_force(irq_force),
    .clr_err(clr_err), .clr_over(clr_over), .clr_under(clr_under), .fifo_pop(fifo_pop),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .conv_err(conv_err), .ready(ready), .ch_sel(ch_sel), .last_result(last_result),
    .last_err(last_err), .err_sticky(err_sticky), .fifo_rdata(fifo_rdata), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_over(fifo_over), .fifo_under(fifo_under),
    .dreq(dreq), .irq_raw(irq_raw), .irq(irq)
  );

  // Behavioural converter stub and start log
  int cyc = 0;
  int n_st = 0;
  int st_cyc [0:255];
  logic [2:0] st_ch [0:255];
  logic [3:0] stub_cnt = 0;
  logic [11:0] stub_d = 0, next_val = 0;
  logic stub_e = 0, next_err = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      n_st <= 0;
      stub_cnt <= 0;
    end else begin
      if (conv_start) begin
        if (n_st < 256) begin
          st_cyc[n_st] <= cyc;
          st_ch[n_st] <= conv_ch;
        end
        n_st <= n_st + 1;
        stub_cnt <= 4'(LAT);
        stub_d <= next_val;
        stub_e <= next_err;
      end else if (stub_cnt != 0) begin
        stub_cnt <= stub_cnt - 4'd1;
      end
    end
  end
  assign conv_done = (stub_cnt == 4'd1);
  assign conv_data = stub_d;
  assign conv_err  = stub_e;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic single(input logic [11:0] v, input logic e);
    next_val = v;
    next_err = e;
    @(negedge clk) start_once = 1'b1;
    @(negedge clk) start_once = 1'b0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    @(negedge clk);
    #1 chk(req, fifo_rdata, exp);
    fifo_pop = 1'b1;
    @(negedge clk) fifo_pop = 1'b0;
  endtask

  function automatic logic [2:0] model_next(input logic [2:0] cur, input logic [4:0] m);
    int c = int'(cur);
    if (m == 0) return cur;
    for (int k = 0; k < 5; k++) begin
      c = (c + 1) % 5;
      if (m[c]) return 3'(c);
    end
    return cur;
  endfunction

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] vals [4];
    int iv [4], fv [4];
    vals[0] = 12'hFFF; vals[1] = 12'h000; vals[2] = 12'h801; vals[3] = 12'h5A5;
    iv[0] = 5; fv[0] = 8'h40; iv[1] = 0; fv[1] = 0; iv[2] = 2; fv[2] = 8'hC0; iv[3] = 6; fv[3] = 8'h55;

    do_reset();
    // R13 reset state
    #1;
    chk("R13 empty", fifo_empty, 1);
    chk("R13 level", fifo_level, 0);
    chk("R13 ch", ch_sel, 0);
    chk("R13 result", last_result, 0);
    chk("R13 flags", {err_sticky, fifo_over, fifo_under, irq, dreq}, 0);
    // R1 disabled: no start, not ready
    chk("R1 ready off", ready, 0);
    single(12'h123, 1'b0);
    chk("R1 no start when disabled", n_st, 0);

    // R2 single shot, pulse while busy ignored
    adc_en = 1'b1;
    @(negedge clk);
    #1 chk("R1 ready on", ready, 1);
    next_val = 12'h321; next_err = 1'b0;
    @(negedge clk) start_once = 1'b1;
    @(negedge clk) start_once = 1'b0;
    #1 chk("R2 busy", ready, 0);
    @(negedge clk) start_once = 1'b1;
    @(negedge clk) start_once = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk("R2 one start", n_st, 1);
    chk("R1 ready back", ready, 1);
    chk("R5 result", last_result, 12'h321);

    // R4 round robin over every mask
    for (int m = 0; m < 32; m++) begin
      logic [2:0] exp_ch;
      int base;
      rr_mask = 5'(m);
      @(negedge clk) begin ch_wr_en = 1'b1; ch_wr_val = 3'(m % 5); end
      @(negedge clk) ch_wr_en = 1'b0;
      exp_ch = 3'(m % 5);
      base = n_st;
      for (int k = 0; k < 6; k++) begin
        single(12'(k), 1'b0);
        chk("R4 conv_ch", st_ch[base + k], exp_ch);
        exp_ch = model_next(exp_ch, 5'(m));
      end
      chk("R4 ch_sel", ch_sel, exp_ch);
      do_reset();
    end

    // R5, R6, R7: formatting sweep, error flags
    adc_en = 1'b1;
    fifo_en = 1'b1;
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 2; s++) begin
        err_tag_en = t[0];
        shift_en = s[0];
        for (int k = 0; k < 4; k++) begin
          single(vals[k], k[0]);
          chk("R5 last_result", last_result, vals[k]);
          chk("R5 last_err", last_err, k[0]);
        end
        chk("R8 full", fifo_full, 1);
        for (int k = 0; k < 4; k++) begin
          logic [11:0] v;
          v = s[0] ? (vals[k] >> 4) : vals[k];
          pop_chk(s[0] ? "R7 shifted entry" : "R6 entry",
                  {(t[0] & k[0]), 3'b000, v});
        end
        chk("R8 empty", fifo_empty, 1);
      end
    end
    chk("R5 sticky held", err_sticky, 1);
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
    chk("R5 sticky cleared", err_sticky, 0);

    // R9 overflow, R8 order, R10 underflow
    err_tag_en = 1'b0; shift_en = 1'b0;
    for (int k = 0; k < 5; k++) single(12'(16 * k + 1), 1'b0);
    chk("R9 over set", fifo_over, 1);
    chk("R9 level", fifo_level, 4);
    for (int k = 0; k < 4; k++) pop_chk("R8 order", 16'(16 * k + 1));
    chk("R9 over held", fifo_over, 1);
    @(negedge clk) clr_over = 1'b1;
    @(negedge clk) clr_over = 1'b0;
    chk("R9 over cleared", fifo_over, 0);
    pop_chk("R10 empty read", 16'h0000);
    chk("R10 under set", fifo_under, 1);
    chk("R10 level", fifo_level, 0);
    @(negedge clk) clr_under = 1'b1;
    @(negedge clk) clr_under = 1'b0;
    chk("R10 under cleared", fifo_under, 0);

    // R11 threshold sweep, R8 level
    for (int l = 0; l <= 4; l++) begin
      chk("R8 level", fifo_level, l);
      chk("R8 full flag", fifo_full, (l == 4));
      chk("R8 empty flag", fifo_empty, (l == 0));
      for (int th = 0; th <= 5; th++) begin
        for (int de = 0; de < 2; de++) begin
          @(negedge clk) begin fifo_thresh = 4'(th); dreq_en = de[0]; end
          #1;
          chk("R11 irq_raw", irq_raw, (l >= th));
          chk("R11 dreq", dreq, (de == 1) && (l >= th));
        end
      end
      if (l < 4) single(12'h0AA, 1'b0);
    end
    // R12 interrupt combinations
    for (int th = 4; th <= 5; th++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk) begin fifo_thresh = 4'(th); irq_en = c[0]; irq_force = c[1]; end
        #1 chk("R12 irq", irq, ((th <= 4) && c[0]) || c[1]);
      end
    end
    irq_en = 0; irq_force = 0; fifo_en = 0;

    // R3 continuous pacing
    for (int cfg = 0; cfg < 4; cfg++) begin
      int acc, sum, ex, guard;
      do_reset();
      adc_en = 1'b1;
      div_int = 16'(iv[cfg]);
      div_frac = 8'(fv[cfg]);
      @(negedge clk) start_many = 1'b1;
      guard = 0;
      while (n_st < 9 && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
      start_many = 1'b0;
      repeat (LAT + 3) @(negedge clk);
      chk("R3 start count", (n_st >= 9), 1);
      acc = 0;
      for (int k = 0; k < 8; k++) begin
        sum = acc + fv[cfg];
        acc = sum % 256;
        ex = iv[cfg] + sum / 256 + 1;
        if (ex < LAT + 1) ex = LAT + 1;
        chk("R3 spacing", st_cyc[k + 1] - st_cyc[k], ex);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule